// File: doc/BRIEF.md
# Way-Predicting Two-Way Read Cache

This block is a two-way set-associative read cache that saves work on the common path. It reads only one way on the first probe. A per-set prediction bit selects that way. When the prediction is right, the data returns in the first cycle after the request is accepted. When it is wrong, the other way is checked in the following cycle. A hit there is a slow hit, and it retrains the prediction bit for that set. When both ways miss, the block asks the next level for the word, writes it into a victim way and forwards it to the requester in the same cycle it arrives.

Each cache line holds one data word. The low `SETS_W` address bits pick the set and the remaining upper bits form the tag. Requests use a valid/ready handshake. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The cache drops `req_ready` while a request is in flight and raises it again in the cycle after the response. The response is a single-cycle pulse with no back-pressure, so the requester must take it when `rsp_valid` is high. The refill port raises `fill_valid` and holds it, together with `fill_addr`, until the next level answers with a one-cycle `fill_rsp_valid`.

Top module: `wpc_cache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `fill_valid` are 0, every line is invalid and every prediction bit selects way 0.
- R2: A request is taken on an edge where `req_valid` and `req_ready` are both high. `req_ready` is 0 from that edge until the cycle after the response, and `rsp_valid` is high for exactly one cycle per request.
- R3: If the predicted way holds the tag, `rsp_valid` rises in the first cycle after acceptance. In that cycle `rsp_kind` is 2'b00, `rsp_way` is the predicted way and `rsp_data` is the stored word.
- R4: If only the other way holds the tag, the response comes in the second cycle after acceptance. `rsp_kind` is 2'b01 and `rsp_way` is that other way.
- R5: A slow hit sets the set's prediction bit to the way that hit, so a repeat of the same address is a fast hit.
- R6: On a miss in both ways, `fill_valid` rises in the third cycle after acceptance with `fill_addr` equal to the request address. It is held until `fill_rsp_valid`. The response (`rsp_kind` 2'b10, `rsp_data` equal to `fill_rsp_data`) appears in the cycle in which `fill_rsp_valid` is high.
- R7: A refill writes way 0 if way 0 is invalid. Otherwise it writes way 1 if way 1 is invalid. Otherwise it writes the way that is not predicted. `rsp_way` reports the way written.
- R8: After a refill, the set's prediction bit names the refilled way.
- R9: The set index is `req_addr[SETS_W-1:0]` and the tag is the remaining upper bits. Sets keep separate lines and prediction bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can take a request |
| req_addr | input | ADDR_W | Word address of the read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Read data |
| rsp_kind | output | 2 | 00 fast hit, 01 slow hit, 10 miss |
| rsp_way | output | 1 | Way that supplied or received the word |
| fill_valid | output | 1 | Refill request to the next level |
| fill_addr | output | ADDR_W | Address to fetch |
| fill_rsp_valid | input | 1 | Next level returns the word |
| fill_rsp_data | input | DATA_W | Word from the next level |

## Verification
The bench targets the prediction flips. In one case a slow hit must retrain the bit. If it does not, the repeat access comes back slow rather than fast. In another case a refill into a full set must evict the way that is not predicted. If the wrong way is evicted, the line used most recently disappears and a later access misses when it should hit. Cold sets check the invalid-way-first rule, where a wrong choice shows up as an unexpected `rsp_way`. Refills are answered after several different delays, so a design that responds before the next level answers, or that drops `fill_valid` early, produces the wrong latency or data.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_ALT   = 2'd2,
    ST_FILL  = 2'd3
  } wpc_state_e;

  localparam logic [1:0] KIND_FAST = 2'b00;
  localparam logic [1:0] KIND_SLOW = 2'b01;
  localparam logic [1:0] KIND_MISS = 2'b10;
endpackage

// File: rtl/wpc_pred_table.sv
module wpc_pred_table #(
  parameter int SETS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SETS_W-1:0] rd_idx,
  output logic              rd_way,
  input  logic              wr_en,
  input  logic [SETS_W-1:0] wr_idx,
  input  logic              wr_way
);
  localparam int SETS = 1 << SETS_W;

  logic [SETS-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= '0;
    else if (wr_en) bits_q[wr_idx] <= wr_way;
  end

  assign rd_way = bits_q[rd_idx];
endmodule

// File: rtl/wpc_way_store.sv
module wpc_way_store #(
  parameter int SETS_W = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SETS_W-1:0] rd_idx,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [SETS_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int SETS = 1 << SETS_W;

  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];
  assign rd_data = data_q[rd_idx];
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
  import wpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       pred_hit,
  input  logic       alt_hit,
  input  logic       fill_rsp_valid,
  output logic       req_ready,
  output wpc_state_e state
);
  wpc_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:  if (req_valid)      state_d = ST_PROBE;
      ST_PROBE: state_d = pred_hit ? ST_IDLE : ST_ALT;
      ST_ALT:   state_d = alt_hit  ? ST_IDLE : ST_FILL;
      ST_FILL:  if (fill_rsp_valid) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  assign req_ready = (state == ST_IDLE);

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/wpc_cache.sv
module wpc_cache
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SETS_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_kind,
  output logic              rsp_way,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_rsp_valid,
  input  logic [DATA_W-1:0] fill_rsp_data
);
  localparam int TAG_W = ADDR_W - SETS_W;
  localparam int WAYS  = 2;

  wpc_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [SETS_W-1:0] idx;
  logic [TAG_W-1:0]  tag;
  logic              pred_way, alt_way, victim;
  logic              pred_hit, alt_hit, fill_done;
  logic              pred_we, pred_wway;
  logic [WAYS-1:0]   way_vld, way_hit, way_we;
  logic [TAG_W-1:0]  way_tag  [WAYS];
  logic [DATA_W-1:0] way_data [WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else if (req_valid && req_ready) addr_q <= req_addr;
  end

  assign idx = addr_q[SETS_W-1:0];
  assign tag = addr_q[ADDR_W-1:SETS_W];

  wpc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pred_hit(pred_hit),
    .alt_hit(alt_hit), .fill_rsp_valid(fill_rsp_valid),
    .req_ready(req_ready), .state(state)
  );

  wpc_pred_table #(.SETS_W(SETS_W)) u_pred (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx), .rd_way(pred_way),
    .wr_en(pred_we), .wr_idx(idx), .wr_way(pred_wway)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    wpc_way_store #(.SETS_W(SETS_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_idx(idx),
      .rd_vld(way_vld[w]), .rd_tag(way_tag[w]), .rd_data(way_data[w]),
      .wr_en(way_we[w]), .wr_idx(idx), .wr_tag(tag), .wr_data(fill_rsp_data)
    );
    assign way_hit[w] = way_vld[w] && (way_tag[w] == tag);
    assign way_we[w]  = fill_done && (victim == 1'(w));
  end

  assign alt_way   = ~pred_way;
  assign pred_hit  = way_hit[pred_way];
  assign alt_hit   = way_hit[alt_way];
  assign victim    = !way_vld[0] ? 1'b0 : (!way_vld[1] ? 1'b1 : alt_way);
  assign fill_done = (state == ST_FILL) && fill_rsp_valid;

  assign pred_we   = ((state == ST_ALT) && alt_hit) || fill_done;
  assign pred_wway = fill_done ? victim : alt_way;

  assign fill_valid = (state == ST_FILL);
  assign fill_addr  = addr_q;

  always_comb begin
    rsp_valid = 1'b0;
    rsp_kind  = KIND_FAST;
    rsp_way   = pred_way;
    rsp_data  = way_data[pred_way];
    if ((state == ST_PROBE) && pred_hit) begin
      rsp_valid = 1'b1;
    end else if ((state == ST_ALT) && alt_hit) begin
      rsp_valid = 1'b1;
      rsp_kind  = KIND_SLOW;
      rsp_way   = alt_way;
      rsp_data  = way_data[alt_way];
    end else if (fill_done) begin
      rsp_valid = 1'b1;
      rsp_kind  = KIND_MISS;
      rsp_way   = victim;
      rsp_data  = fill_rsp_data;
    end
  end

  assert_rsp_reopens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (req_ready && !rsp_valid));
  assert_fill_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_rsp_valid) |=> (fill_valid && $stable(fill_addr)));
  assert_fill_answers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_rsp_valid) |-> (rsp_valid && rsp_kind == KIND_MISS));
  assert_retrain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == KIND_SLOW) |=> (pred_way == $past(rsp_way)));
  assert_refill_pred_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == KIND_MISS) |=> (pred_way == $past(rsp_way)));
  assert_one_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_we));
endmodule

// File: tb/wpc_cache_bench.sv
`timescale 1ns/1ps
module wpc_cache_bench;
  localparam int ADDR_W = 12;
  localparam int SETS_W = 4;
  localparam int DATA_W = 32;
  localparam int SETS   = 1 << SETS_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic [1:0]        rsp_kind;
  logic              rsp_way;
  logic              fill_valid;
  logic [ADDR_W-1:0] fill_addr;
  logic              fill_rsp_valid = 1'b0;
  logic [DATA_W-1:0] fill_rsp_data = '0;

  int n_cmp = 0;
  int n_bad = 0;

  bit              m_vld  [SETS][2];
  logic [7:0]      m_tag  [SETS][2];
  bit              m_pred [SETS];

  always #2 clk = ~clk;

  wpc_cache #(.ADDR_W(ADDR_W), .SETS_W(SETS_W), .DATA_W(DATA_W)) u_wpc_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_kind(rsp_kind), .rsp_way(rsp_way), .fill_valid(fill_valid),
    .fill_addr(fill_addr), .fill_rsp_valid(fill_rsp_valid),
    .fill_rsp_data(fill_rsp_data)
  );

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return {4'h5, a, ~a, 4'hC} ^ 32'h0F1E_2D3C;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, input int d);
    int idx = int'(a[SETS_W-1:0]);
    logic [7:0] tg = a[ADDR_W-1:SETS_W];
    bit pw = m_pred[idx];
    int ekind, elat, cyc, fw;
    bit eway;
    string rq;
    if (m_vld[idx][pw] && m_tag[idx][pw] == tg) begin
      ekind = 0; eway = pw; elat = 1; rq = "R3";
    end else if (m_vld[idx][!pw] && m_tag[idx][!pw] == tg) begin
      ekind = 1; eway = !pw; elat = 2; rq = "R4_R5";
      m_pred[idx] = !pw;
    end else begin
      ekind = 2; elat = 3 + d; rq = "R6_R7_R8";
      eway = !m_vld[idx][0] ? 1'b0 : (!m_vld[idx][1] ? 1'b1 : !pw);
      m_vld[idx][eway] = 1'b1;
      m_tag[idx][eway] = tg;
      m_pred[idx] = eway;
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before request", 32'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    fw  = 0;
    while (cyc <= 64) begin
      fill_rsp_valid = 1'b0;
      if (fill_valid) begin
        if (fw == d) begin
          fill_rsp_valid = 1'b1;
          fill_rsp_data  = mem_word(fill_addr);
        end
        fw++;
      end
      #1;
      chk(fill_valid == (ekind == 2 && cyc >= 3), "R6", "fill_valid timing",
          32'(fill_valid), 32'(ekind == 2 && cyc >= 3));
      if (fill_valid)
        chk(fill_addr == a, "R6_R9", "fill_addr", 32'(fill_addr), 32'(a));
      chk(req_ready == 1'b0, "R2", "ready while busy", 32'(req_ready), 0);
      if (rsp_valid) break;
      @(negedge clk);
      cyc++;
    end
    if (cyc > 64) begin
      chk(1'b0, "R2", "response watchdog", 32'(cyc), 32'(elat));
    end else begin
      chk(cyc == elat, rq, "latency", 32'(cyc), 32'(elat));
      chk(rsp_kind == 2'(ekind), rq, "rsp_kind", 32'(rsp_kind), 32'(ekind));
      chk(rsp_way == eway, rq, "rsp_way", 32'(rsp_way), 32'(eway));
      chk(rsp_data == mem_word(a), rq, "rsp_data", rsp_data, mem_word(a));
    end
    @(negedge clk);
    fill_rsp_valid = 1'b0;
    #1;
    chk(rsp_valid == 1'b0, "R2", "single-cycle response", 32'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R2", "ready after response", 32'(req_ready), 1);
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "R2", "global watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int s = 0; s < SETS; s++) begin
      m_pred[s] = 1'b0;
      m_vld[s][0] = 1'b0;
      m_vld[s][1] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: idle outputs after reset
    chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    chk(fill_valid == 1'b0, "R1", "fill_valid after reset", 32'(fill_valid), 0);

    // Directed walk through set 3: cold miss, fast, second tag, slow, evictions (R1 R3 R4 R5 R7 R8)
    access(12'h0A3, 0);
    access(12'h0A3, 0);
    access(12'h0B3, 1);
    access(12'h0A3, 0);
    access(12'h0A3, 0);
    access(12'h0B3, 0);
    access(12'h0B3, 0);
    access(12'h0C3, 2);
    access(12'h0A3, 0);
    access(12'h0C3, 0);
    access(12'h0B3, 3);
    // Set boundaries are independent (R9)
    access(12'h000, 0);
    access(12'hFFF, 1);
    access(12'h00F, 0);
    access(12'hFF0, 0);
    access(12'h000, 0);
    access(12'hFFF, 0);

    // Pseudo-random sweep over few tags so sets fill and thrash
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access({6'd0, lfsr[5:4], lfsr[3:0]} ^ {4'd0, 4'(lfsr[9:8]), 4'd0}, int'(lfsr[11:10]));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule